// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the interrupt status and the interrupt masks for one 16-bit timer/counter that has three output-compare channels (A, B, C), one input-capture channel and an overflow event. The counter core feeds it single-cycle event pulses: a compare equality per channel, a forced-compare strobe per channel, a capture edge, a counter-at-TOP pulse and an overflow pulse. A mode input tells it whether the capture register currently acts as TOP.

Software reaches the block through a one-byte write port that selects either the flag byte or the enable byte. An interrupt controller sees one request line per source and returns one acknowledge strobe per source when it takes that vector. The timer clock is a clock-enable (`tick`) on the system clock. Event sampling advances only on ticked cycles, while writes and acknowledges act on every system clock cycle.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, `flag_byte`, `en_byte` and `irq_req` are all zero.
- R2: Both bytes use the same layout: bit0 overflow, bit1 compare A, bit2 compare B, bit3 compare C, bit5 capture. Bits 4, 6 and 7 always read 0, and writing 1 to them has no effect. Source index i of `ack` and `irq_req` is ordered overflow, A, B, C, capture.
- R3: A write with `wr_sel`=0 clears every flag whose bit in `wr_data` is 1. Flags whose bit is 0 keep their value.
- R4: An `ack` pulse on a source clears that source's flag on the next edge.
- R5: A compare flag is set by the second ticked edge after a ticked cycle with `cmp_match` high. The first ticked edge does not set it.
- R6: A ticked cycle with `cmp_force` high on a channel never leads to that channel's flag being set, even when `cmp_match` is also high.
- R7: When `top_is_cap`=0, a ticked `cap_edge` sets the capture flag on that edge. When `top_is_cap`=1, `cnt_top` sets it and `cap_edge` is ignored.
- R8: A ticked `ovf` sets the overflow flag on that edge.
- R9: `irq_req[i]` is 1 exactly when source i's flag is set, its enable bit is 1 and `gie` is 1.
- R10: When a set and a clear (write-one or ack) reach the same flag on the same edge, the flag ends up set.
- R11: With `tick`=0, event inputs change no flag and do not change a pending compare. Writes with `wr_sel`=1 load the enable byte on any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| cmp_match | input | 3 | Counter equals compare value, per channel A..C |
| cmp_force | input | 3 | Forced-compare strobe, per channel |
| cap_edge | input | 1 | Capture event at the capture input |
| cnt_top | input | 1 | Counter reached TOP |
| top_is_cap | input | 1 | Capture register serves as TOP |
| ovf | input | 1 | Counter overflow |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = flag byte, 1 = enable byte |
| wr_data | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| ack | input | 5 | Vector-taken strobes, per source |
| irq_req | output | 5 | Interrupt requests, per source |
| flag_byte | output | 8 | Flag register read value |
| en_byte | output | 8 | Enable register read value |

## Verification
The hardest case to reach is a compare match that is still pending in the one-tick delay stage while `tick` stays low for several cycles. During that gap, writes, acknowledges and a forced strobe arrive, and then the delayed set meets a clear on the same edge. Directed sequences build this case step by step. A long random phase then mixes sparse ticks with dense writes and acknowledges. A cycle-accurate model queues the expected bytes and requests for every cycle.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int REG_W = 8;
  localparam int NCMP  = 3;
  localparam int NSRC  = NCMP + 2;
  localparam int SRC_OVF = 0;
  localparam int SRC_CAP = NSRC - 1;
  localparam int CAP_POS = 5;
  localparam logic [REG_W-1:0] LAYOUT_MASK = 8'h2F;

  function automatic int src_pos(input int idx);
    return (idx == SRC_CAP) ? CAP_POS : idx;
  endfunction
endpackage

// File: rtl/tif_cmp_delay.sv
module tif_cmp_delay #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] match_i,
  input  logic [N-1:0] force_i,
  output logic [N-1:0] set_o
);
  logic [N-1:0] pend_q;

  for (genvar c = 0; c < N; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)    pend_q[c] <= 1'b0;
      else if (tick) pend_q[c] <= match_i[c] & ~force_i[c];
    end

    assign set_o[c] = tick & pend_q[c];

    assert_force_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && force_i[c]) |=> !pend_q[c]);
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pend_q[c]));
  end
endmodule

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCMP-1:0]  cmp_match,
  input  logic [NCMP-1:0]  cmp_force,
  input  logic             cap_edge,
  input  logic             cnt_top,
  input  logic             top_is_cap,
  input  logic             ovf,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             gie,
  input  logic [NSRC-1:0]  ack,
  output logic [NSRC-1:0]  irq_req,
  output logic [REG_W-1:0] flag_byte,
  output logic [REG_W-1:0] en_byte
);
  logic [NCMP-1:0] cmp_set;
  logic [NSRC-1:0] set_src;
  logic [NSRC-1:0] clr_src;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_q;
  logic            flag_wr;
  logic            en_wr;

  assign flag_wr = wr_en & ~wr_sel;
  assign en_wr   = wr_en &  wr_sel;

  tif_cmp_delay #(.N(NCMP)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .match_i(cmp_match),
    .force_i(cmp_force),
    .set_o  (cmp_set)
  );

  always_comb begin
    set_src                 = '0;
    set_src[SRC_OVF]        = tick & ovf;
    set_src[NCMP:1]         = cmp_set;
    set_src[SRC_CAP]        = tick & (top_is_cap ? cnt_top : cap_edge);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int POS = src_pos(i);

    assign clr_src[i] = ack[i] | (flag_wr & wr_data[POS]);

    tif_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_src[i]),
      .clr_i (clr_src[i]),
      .flag_o(flag_q[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)     en_q[i] <= 1'b0;
      else if (en_wr) en_q[i] <= wr_data[POS];
    end

    assign irq_req[i] = gie & en_q[i] & flag_q[i];

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] |-> (flag_byte[POS] && en_byte[POS] && gie));
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set_src[i]) |=> !flag_byte[POS]);
  end

  always_comb begin
    flag_byte = '0;
    en_byte   = '0;
    for (int i = 0; i < NSRC; i++) begin
      flag_byte[src_pos(i)] = flag_q[i];
      en_byte[src_pos(i)]   = en_q[i];
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_byte | en_byte) & ~LAYOUT_MASK) == '0);
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en && ack == '0) |=> $stable(flag_byte));
  assert_no_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq_req == '0);
endmodule

// File: tb/tmr_irq_flags_tb.sv
module tmr_irq_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, cap_edge = 0, cnt_top = 0, top_is_cap = 0, ovf = 0;
  logic wr_en = 0, wr_sel = 0, gie = 0;
  logic [2:0] cmp_match = 0, cmp_force = 0;
  logic [7:0] wr_data = 0;
  logic [4:0] ack = 0;
  logic [4:0] irq_req;
  logic [7:0] flag_byte, en_byte;

  always #2.5 clk = ~clk;

  tmr_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_match(cmp_match),
    .cmp_force(cmp_force), .cap_edge(cap_edge), .cnt_top(cnt_top),
    .top_is_cap(top_is_cap), .ovf(ovf), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .gie(gie), .ack(ack), .irq_req(irq_req),
    .flag_byte(flag_byte), .en_byte(en_byte)
  );

  typedef struct {
    logic [7:0] f;
    logic [7:0] e;
    logic [4:0] irq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic [7:0] m_flag = 0, m_en = 0;
  logic [2:0] m_pend = 0;

  function automatic int pos(input int i);
    return (i == 4) ? 5 : i;
  endfunction

  function automatic logic [4:0] irq_of(input logic [7:0] f, input logic [7:0] e, input logic g);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = g & f[pos(i)] & e[pos(i)];
    return r;
  endfunction

  task automatic cyc(input string tag);
    logic [7:0] set, clr;
    exp_t x;
    set = 0;
    clr = 0;
    if (tick) begin
      set[0] = ovf;
      set[5] = top_is_cap ? cnt_top : cap_edge;
      for (int c = 0; c < 3; c++) set[c+1] = m_pend[c];
      m_pend = cmp_match & ~cmp_force;
    end
    if (wr_en && !wr_sel) clr = wr_data;
    for (int i = 0; i < 5; i++) if (ack[i]) clr[pos(i)] = 1'b1;
    m_flag = ((m_flag & ~clr) | set) & 8'h2F;
    if (wr_en && wr_sel) m_en = wr_data & 8'h2F;
    x.f = m_flag; x.e = m_en; x.irq = irq_of(m_flag, m_en, gie); x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk);
    tick = 0; cmp_match = 0; cmp_force = 0; cap_edge = 0; cnt_top = 0; ovf = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0; ack = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      checks++;
      if (flag_byte !== x.f || en_byte !== x.e || irq_req !== x.irq) begin
        errors++;
        $display("FAIL %s: flags=%h en=%h irq=%b expected flags=%h en=%h irq=%b",
                 x.tag, flag_byte, en_byte, irq_req, x.f, x.e, x.irq);
      end
    end
  end

  initial begin
    #50000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (flag_byte !== 0 || en_byte !== 0 || irq_req !== 0) begin
      errors++;
      $display("FAIL R1: flags=%h en=%h irq=%b expected all zero", flag_byte, en_byte, irq_req);
    end
    rst_n = 1;
    @(negedge clk);
    // R1 idle check and R2 reserved-bit write on enables
    cyc("R1");
    gie = 1; wr_en = 1; wr_sel = 1; wr_data = 8'hFF; cyc("R2");
    // R8 overflow sets on the ticked edge, R9 request follows
    tick = 1; ovf = 1; cyc("R8");
    ovf = 1; cyc("R11");              // no tick: ignored
    // R3 write zero keeps, write one clears
    wr_en = 1; wr_data = 8'hD0; cyc("R3");
    wr_en = 1; wr_data = 8'h01; cyc("R3");
    // R5 compare A: match, then idle gap, then two ticks
    tick = 1; cmp_match = 3'b001; cyc("R5");
    cmp_match = 3'b111; cyc("R11");   // untucked match must not disturb pending
    cyc("R11");
    tick = 1; cyc("R5");
    tick = 1; cyc("R5");
    // R6 forced strobe alongside a match
    tick = 1; cmp_match = 3'b110; cmp_force = 3'b110; cyc("R6");
    tick = 1; cyc("R6");
    tick = 1; cyc("R6");
    // R7 capture source select
    tick = 1; cap_edge = 1; cyc("R7");
    wr_en = 1; wr_data = 8'h20; cyc("R3");
    top_is_cap = 1; tick = 1; cap_edge = 1; cyc("R7");
    top_is_cap = 1; tick = 1; cnt_top = 1; cyc("R7");
    // R4 acknowledge clear
    ack = 5'b10000; cyc("R4");
    tick = 1; ovf = 1; cyc("R8");
    ack = 5'b00001; cyc("R4");
    // R10 set and clear collide
    tick = 1; ovf = 1; ack = 5'b00001; cyc("R10");
    tick = 1; cmp_match = 3'b100; cyc("R10");
    tick = 1; wr_en = 1; wr_data = 8'h2F; ack = 5'b11111; cyc("R10");
    // R9 masking by enable and gie
    wr_en = 1; wr_sel = 1; wr_data = 8'h01; cyc("R9");
    gie = 0; cyc("R9");
    gie = 1; cyc("R9");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      tick = ($urandom_range(0, 3) == 0);
      cmp_match = 3'($urandom);
      cmp_force = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      cap_edge = 1'($urandom); cnt_top = 1'($urandom);
      top_is_cap = ($urandom_range(0, 7) == 0) ? ~top_is_cap : top_is_cap;
      ovf = 1'($urandom);
      wr_en = ($urandom_range(0, 3) == 0);
      wr_sel = 1'($urandom);
      wr_data = 8'($urandom);
      gie = ($urandom_range(0, 7) != 0);
      ack = ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'b0;
      cyc("R10 R9 random");
    end
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule